// File: doc/BRIEF.md
# Floating-point NaN propagation selector

This block decides what a single-precision floating-point operation must return when NaNs or an invalid product are involved. It takes two or three operands (the three-operand case is a fused multiply-add computed as a*b+c), classifies each operand from its bit pattern, and reports three things. The first is whether the result is a NaN. The second is the exact 32-bit NaN value to return. The third is whether the invalid-operation flag must be raised. The arithmetic datapath runs in parallel and uses the result of this block only when the NaN strobe is high.

Two rule sets are available, chosen by a mode input. The standard set prefers signalling NaNs, and then prefers operands in the order C, A, B for three operands or A, B for two. The alternate set takes the first NaN in operand order A, B, C. The two sets also treat the zero-times-infinity-plus-NaN case differently, and they use default NaNs of opposite sign. A default-NaN enable replaces every NaN result with the default NaN of the selected mode. The decision is registered, so the outputs are valid one clock after the operands are presented.

Top module: `nan_pick`

## Requirements
- R1: While reset is low all outputs are 0. Otherwise the outputs reflect the inputs sampled at the previous rising clock edge and hold until the next edge.
- R2: Standard mode (alt_mode_i=0), two operands (three_op_i=0): a signalling NaN wins over a quiet NaN. Between NaNs of the same kind, A wins over B.
- R3: Alternate mode (alt_mode_i=1), two operands: the result is the first NaN in the order A then B, whether it is signalling or quiet.
- R4: Standard mode, three operands: the result is the first match in the order signalling C, signalling A, signalling B, quiet C, quiet A, quiet B.
- R5: Alternate mode, three operands: the result is the first NaN in the order A, B, C.
- R6: A propagated NaN is returned with fraction bit 22 set. The sign bit, the exponent and all other fraction bits are kept. A NaN is a value with exponent bits 30:23 all ones and a nonzero fraction. It is quiet when bit 22 is 1 and signalling when bit 22 is 0.
- R7: inv_o is 1 whenever any operand in use is a signalling NaN. If no operand in use is a NaN and there is no zero-times-infinity product, nan_vld_o, res_o and inv_o are all 0.
- R8: Standard mode, three operands: if one of A and B is zero and the other is infinite, a quiet NaN C gives the default NaN 0x7FC00000, and a signalling NaN C gives C quietened. inv_o is 1 in both cases.
- R9: Alternate mode, three operands: if one of A and B is zero and the other is infinite and C is a NaN, the result is C quietened. inv_o equals 1 only when C is signalling.
- R10: Three operands with a zero-times-infinity product and no NaN input: the result is the mode's default NaN (0x7FC00000 in standard mode, 0xFFC00000 in alternate mode) and inv_o is 1. With two operands, a zero and an infinity produce no result (all outputs 0).
- R11: When dflt_nan_en_i is 1, every NaN result is replaced by the mode's default NaN. inv_o is unchanged, and a non-NaN outcome stays non-NaN.
- R12: With three_op_i=0, operand C has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_mode_i | input | 1 | 0 = standard rule set, 1 = alternate rule set |
| dflt_nan_en_i | input | 1 | Force the default NaN on every NaN result |
| three_op_i | input | 1 | 1 = three-operand a*b+c, 0 = two-operand |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| op_c_i | input | 32 | Operand C (addend) |
| nan_vld_o | output | 1 | The result is a NaN given on res_o |
| res_o | output | 32 | Selected NaN value, 0 when nan_vld_o is 0 |
| inv_o | output | 1 | Invalid-operation flag |

## Verification
The only state is the single output register, so a fault shows at the ports one clock after the offending operands. It shows as a wrong payload, a wrong sign, a missing quiet bit or a wrong invalid flag. A wrong priority between operands is visible only when two or more operands are NaNs of the same or different kinds. For that reason the directed cases place signalling and quiet NaNs with distinct payloads in every position. A fault in the zero-times-infinity path appears only when that product is present, with a quiet addend, with a signalling addend and with no NaN addend, in both modes.

// File: rtl/nan_pick.sv
module nan_pick #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alt_mode_i,
  input  logic                       dflt_nan_en_i,
  input  logic                       three_op_i,
  input  logic [EXP_W+MAN_W:0]       op_a_i,
  input  logic [EXP_W+MAN_W:0]       op_b_i,
  input  logic [EXP_W+MAN_W:0]       op_c_i,
  output logic                       nan_vld_o,
  output logic [EXP_W+MAN_W:0]       res_o,
  output logic                       inv_o
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int QB = MAN_W - 1;

  function automatic logic exp_max(input logic [W-1:0] x);
    return &x[W-2:MAN_W];
  endfunction

  function automatic logic is_nan(input logic [W-1:0] x);
    return exp_max(x) && (|x[MAN_W-1:0]);
  endfunction

  function automatic logic is_snan(input logic [W-1:0] x);
    return is_nan(x) && !x[QB];
  endfunction

  function automatic logic is_inf(input logic [W-1:0] x);
    return exp_max(x) && !(|x[MAN_W-1:0]);
  endfunction

  function automatic logic is_zero(input logic [W-1:0] x);
    return !(|x[W-2:0]);
  endfunction

  logic na, nb, nc, sa, sb, sc, qa, qb, qc, inf_zero;
  assign na = is_nan(op_a_i);
  assign nb = is_nan(op_b_i);
  assign nc = is_nan(op_c_i);
  assign sa = is_snan(op_a_i);
  assign sb = is_snan(op_b_i);
  assign sc = is_snan(op_c_i);
  assign qa = na && !sa;
  assign qb = nb && !sb;
  assign qc = nc && !sc;
  assign inf_zero = (is_inf(op_a_i) && is_zero(op_b_i)) ||
                    (is_zero(op_a_i) && is_inf(op_b_i));

  logic [W-1:0] dnan, quiet_mask;
  assign dnan       = {alt_mode_i, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  assign quiet_mask = W'(1) << QB;

  logic         hit, use_dn, inv_d;
  logic [W-1:0] pick;

  always_comb begin
    hit    = 1'b0;
    use_dn = 1'b0;
    inv_d  = 1'b0;
    pick   = '0;
    if (!three_op_i) begin
      hit   = na || nb;
      inv_d = sa || sb;
      if (alt_mode_i) begin
        if (na)      pick = op_a_i;
        else if (nb) pick = op_b_i;
      end else begin
        if (sa)      pick = op_a_i;
        else if (sb) pick = op_b_i;
        else if (qa) pick = op_a_i;
        else if (qb) pick = op_b_i;
      end
    end else begin
      hit   = na || nb || nc || inf_zero;
      inv_d = sa || sb || sc;
      if (inf_zero && nc) begin
        if (alt_mode_i) begin
          pick  = op_c_i;
          inv_d = sc;
        end else begin
          inv_d = 1'b1;
          if (sc) pick = op_c_i;
          else    use_dn = 1'b1;
        end
      end else if (na || nb || nc) begin
        if (alt_mode_i) begin
          if (na)      pick = op_a_i;
          else if (nb) pick = op_b_i;
          else         pick = op_c_i;
        end else begin
          if (sc)      pick = op_c_i;
          else if (sa) pick = op_a_i;
          else if (sb) pick = op_b_i;
          else if (qc) pick = op_c_i;
          else if (qa) pick = op_a_i;
          else         pick = op_b_i;
        end
      end else if (inf_zero) begin
        use_dn = 1'b1;
        inv_d  = 1'b1;
      end
    end
  end

  logic [W-1:0] res_d;
  assign res_d = !hit ? '0 :
                 (use_dn || dflt_nan_en_i) ? dnan : (pick | quiet_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nan_vld_o <= 1'b0;
      res_o     <= '0;
      inv_o     <= 1'b0;
    end else begin
      nan_vld_o <= hit;
      res_o     <= res_d;
      inv_o     <= inv_d;
    end
  end
endmodule

// File: rtl/nan_pick_chk.sv
module nan_pick_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 alt_mode_i,
  input logic                 dflt_nan_en_i,
  input logic                 three_op_i,
  input logic [EXP_W+MAN_W:0] op_a_i,
  input logic [EXP_W+MAN_W:0] op_b_i,
  input logic [EXP_W+MAN_W:0] op_c_i,
  input logic                 nan_vld_o,
  input logic [EXP_W+MAN_W:0] res_o,
  input logic                 inv_o
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int QB = MAN_W - 1;
  localparam logic [W-1:0] DN_STD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] DN_ALT = {1'b1, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_s, b_s, c_s, a_n, b_n, c_q, prod_iz;
  assign a_n = (&op_a_i[W-2:MAN_W]) && (|op_a_i[MAN_W-1:0]);
  assign b_n = (&op_b_i[W-2:MAN_W]) && (|op_b_i[MAN_W-1:0]);
  assign a_s = a_n && !op_a_i[QB];
  assign b_s = b_n && !op_b_i[QB];
  assign c_s = (&op_c_i[W-2:MAN_W]) && !op_c_i[QB] && (|op_c_i[QB-1:0]);
  assign c_q = (&op_c_i[W-2:MAN_W]) && op_c_i[QB];
  assign prod_iz = ((&op_a_i[W-2:MAN_W]) && !(|op_a_i[MAN_W-1:0]) && !(|op_b_i[W-2:0])) ||
                   ((&op_b_i[W-2:MAN_W]) && !(|op_b_i[MAN_W-1:0]) && !(|op_a_i[W-2:0]));

  AST_RESULT_IS_QNAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nan_vld_o |-> ((&res_o[W-2:MAN_W]) && res_o[QB])); // R6

  AST_SNAN_RAISES_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_s || b_s || (three_op_i && c_s)) |=> inv_o); // R7

  AST_INV_NEEDS_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> nan_vld_o); // R7

  AST_TWO_OP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!three_op_i && !a_n && !b_n) |=> (!nan_vld_o && !inv_o && res_o == '0)); // R12

  AST_DNAN_STD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dflt_nan_en_i && !alt_mode_i) |=> (!nan_vld_o || res_o == DN_STD)); // R11

  AST_DNAN_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dflt_nan_en_i && alt_mode_i) |=> (!nan_vld_o || res_o == DN_ALT)); // R11

  AST_ALT_IZ_QNAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_mode_i && three_op_i && prod_iz && c_q && !dflt_nan_en_i)
      |=> (!inv_o && nan_vld_o && res_o == $past(op_c_i))); // R9

  AST_STD_IZ_QNAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alt_mode_i && three_op_i && prod_iz && c_q)
      |=> (inv_o && res_o == DN_STD)); // R8
endmodule

bind nan_pick nan_pick_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .alt_mode_i(alt_mode_i),
  .dflt_nan_en_i(dflt_nan_en_i), .three_op_i(three_op_i),
  .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i),
  .nan_vld_o(nan_vld_o), .res_o(res_o), .inv_o(inv_o)
);

// File: tb/nan_pick_test.sv
`timescale 1ns/1ps
module nan_pick_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt = 1'b0, den = 1'b0, three = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic        vld, inv;
  logic [31:0] res;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [31:0] QN1  = 32'h7FC00001;
  localparam logic [31:0] QN2  = 32'hFFC00002;
  localparam logic [31:0] SN1  = 32'h7F800011;
  localparam logic [31:0] SN1Q = 32'h7FC00011;
  localparam logic [31:0] SN2  = 32'hFF800022;
  localparam logic [31:0] SN2Q = 32'hFFC00022;
  localparam logic [31:0] INF  = 32'h7F800000;
  localparam logic [31:0] ZRO  = 32'h00000000;
  localparam logic [31:0] ONE  = 32'h3F800000;
  localparam logic [31:0] DNS  = 32'h7FC00000;
  localparam logic [31:0] DNA  = 32'hFFC00000;

  always #10 clk = ~clk;

  nan_pick uut (
    .clk_i(clk), .rst_ni(rst_n), .alt_mode_i(alt), .dflt_nan_en_i(den),
    .three_op_i(three), .op_a_i(a), .op_b_i(b), .op_c_i(c),
    .nan_vld_o(vld), .res_o(res), .inv_o(inv)
  );

  task automatic check(input string tag, input logic ev, input logic [31:0] er, input logic ei);
    n_run++;
    if (vld !== ev || res !== er || inv !== ei) begin
      n_fail++;
      $display("FAIL %s: got vld=%b res=%h inv=%b, expected vld=%b res=%h inv=%b",
               tag, vld, res, inv, ev, er, ei);
    end
  endtask

  task automatic apply(input logic m, input logic d, input logic t,
                       input logic [31:0] xa, input logic [31:0] xb, input logic [31:0] xc);
    @(negedge clk);
    alt = m; den = d; three = t; a = xa; b = xb; c = xc;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset", 1'b0, 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    apply(0, 0, 0, QN1, ONE, ONE);
    @(negedge clk);
    alt = 0; den = 0; three = 0; a = SN2; b = ONE; c = ONE;
    #2 check("R1 holds until edge", 1'b1, QN1, 1'b0);
    @(negedge clk);
    check("R1 updates after edge", 1'b1, SN2Q, 1'b1);
  endtask

  task automatic t_two_std;
    apply(0, 0, 0, QN1, SN2, ONE); check("R2 snan B over qnan A", 1, SN2Q, 1);
    apply(0, 0, 0, QN1, QN2, ONE); check("R2 qnan A over qnan B", 1, QN1, 0);
    apply(0, 0, 0, SN1, SN2, ONE); check("R2 snan A over snan B", 1, SN1Q, 1);
    apply(0, 0, 0, ONE, QN2, ONE); check("R2 only B nan", 1, QN2, 0);
  endtask

  task automatic t_two_alt;
    apply(1, 0, 0, QN1, SN2, ONE); check("R3 first nan A", 1, QN1, 1);
    apply(1, 0, 0, ONE, SN2, ONE); check("R3 B when A numeric", 1, SN2Q, 1);
  endtask

  task automatic t_three_std;
    apply(0, 0, 1, QN1, SN1, QN2); check("R4 snan B over qnan C", 1, SN1Q, 1);
    apply(0, 0, 1, SN1, ONE, SN2); check("R4 snan C over snan A", 1, SN2Q, 1);
    apply(0, 0, 1, QN1, QN2, ONE); check("R4 qnan A over qnan B", 1, QN1, 0);
    apply(0, 0, 1, QN1, ONE, QN2); check("R4 qnan C over qnan A", 1, QN2, 0);
  endtask

  task automatic t_three_alt;
    apply(1, 0, 1, QN1, SN1, SN2); check("R5 A first", 1, QN1, 1);
    apply(1, 0, 1, ONE, QN2, SN1); check("R5 B over C", 1, QN2, 1);
    apply(1, 0, 1, ONE, ONE, QN1); check("R5 C last", 1, QN1, 0);
  endtask

  task automatic t_quiet;
    apply(0, 0, 0, 32'hFFA00005, ONE, ONE); check("R6 quieten keeps sign and payload", 1, 32'hFFE00005, 1);
    apply(0, 0, 0, ONE, ONE, ONE); check("R7 no nan no flag", 0, 32'h0, 0);
  endtask

  task automatic t_inf_zero;
    apply(0, 0, 1, INF, ZRO, QN2); check("R8 std 0*inf+qnan", 1, DNS, 1);
    apply(0, 0, 1, ZRO, INF, SN1); check("R8 std 0*inf+snan", 1, SN1Q, 1);
    apply(1, 0, 1, INF, ZRO, QN2); check("R9 alt 0*inf+qnan", 1, QN2, 0);
    apply(1, 0, 1, ZRO, INF, SN1); check("R9 alt 0*inf+snan", 1, SN1Q, 1);
    apply(0, 0, 1, INF, ZRO, ONE); check("R10 std 0*inf no nan", 1, DNS, 1);
    apply(1, 0, 1, ZRO, INF, ONE); check("R10 alt 0*inf no nan", 1, DNA, 1);
    apply(0, 0, 0, INF, ZRO, ONE); check("R10 two-op inf zero", 0, 32'h0, 0);
  endtask

  task automatic t_dnan;
    apply(0, 1, 0, SN2, ONE, ONE); check("R11 std forced", 1, DNS, 1);
    apply(1, 1, 1, ONE, QN1, ONE); check("R11 alt forced", 1, DNA, 0);
    apply(1, 1, 1, ONE, ONE, ONE); check("R11 no nan stays clear", 0, 32'h0, 0);
  endtask

  task automatic t_ignore_c;
    apply(0, 0, 0, ONE, ONE, SN1); check("R12 snan C ignored", 0, 32'h0, 0);
    apply(0, 0, 0, QN1, ONE, SN1); check("R12 C not chosen", 1, QN1, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset;
    t_two_std;
    t_two_alt;
    t_three_std;
    t_three_alt;
    t_quiet;
    t_inf_zero;
    t_dnan;
    t_ignore_c;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule